// File: doc/BRIEF.md
# Trap Vector Base Register with Write Legalization

This block holds the trap-vector base register of a processor core. The register has a two-bit mode field in bits [1:0] and the handler base address in bits [XLEN-1:2]. Software writes to it through the CSR path. Each write is legalized before it is stored, so reads only ever return a legal value and a write of any value never raises an exception.

Three parameters set the legalization. The first says whether vectored mode exists at all. The second sets the policy for an unsupported mode encoding: keep the mode already held, or fold the encoding onto a legal mode. The third forces the low base bits to zero, to give 64-byte or 4 KiB alignment whatever the mode.

On every trap the block also computes the handler PC. It uses the stored mode, whether the trap is an interrupt, and the cause number. The result is registered and appears one cycle after the trap request, together with a valid strobe.

Top module: `tvec_reg`

## Requirements
- R1: After synchronous reset, `rd_data` is zero (direct mode, base 0) and `trap_pc_vld` is low.
- R2: A write whose bits [1:0] are 00 or 01 stores that mode and the base bits (after alignment masking). The stored value is visible on `rd_data` in the cycle after the write.
- R3: Bit 1 of `rd_data` reads zero at all times, so mode encodings 10 and 11 are never held.
- R4: With the keep policy (MAP_ILLEGAL=0), a write with bit 1 set updates the base bits and leaves the stored mode unchanged.
- R5: With the map policy (MAP_ILLEGAL=1), a write with bit 1 set stores mode {0, bit 0}: 10 becomes 00 and 11 becomes 01.
- R6: With ALIGN_LVL=1, base bits [5:2] always read zero.
- R7: With ALIGN_LVL=2, base bits [11:2] always read zero.
- R8: With VEC_EN=0, the mode bits read 00 after any write.
- R9: In direct mode (mode 00), every trap targets {rd_data[XLEN-1:2], 00}, including interrupts.
- R10: In vectored mode (mode 01), an interrupt targets the base plus 4 × `trap_cause`.
- R11: A synchronous exception (`trap_irq`=0) targets the base in either mode.
- R12: `trap_pc_vld` is high exactly in the cycle after `trap_req`. The target is computed from the register value held before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | XLEN | Raw value written by software |
| rd_data | output | XLEN | Legalized register contents |
| trap_req | input | 1 | A trap is taken this cycle |
| trap_irq | input | 1 | 1 = interrupt, 0 = synchronous exception |
| trap_cause | input | CAUSE_W | Cause number of the trap |
| trap_pc | output | XLEN | Registered handler target PC |
| trap_pc_vld | output | 1 | High in the cycle after a trap request |

## Verification
The hardest case to reach is a write with an illegal mode landing on a register that already holds vectored mode. Under the keep policy the mode must survive while the base changes. That change shows only in a following interrupt, whose target must still be offset by the cause.

The stimulus first programs vectored mode, then writes 10 and 11 mode patterns, and then issues interrupts. It also raises a trap and a write in the same cycle, to show that the target comes from the old contents. Three instances run side by side on the same stimulus: keep policy, map policy with 64-byte alignment, and direct-only with 4 KiB alignment.

// File: rtl/tvec_pkg.sv
package tvec_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'b00,
    MODE_VECTORED = 2'b01
  } tvec_mode_e;

  localparam int ALIGN_NONE = 0;
  localparam int ALIGN_64B  = 1;
  localparam int ALIGN_4K   = 2;

  // number of base bits above bit 1 that are forced to zero
  function automatic int clear_span(input int lvl);
    case (lvl)
      ALIGN_64B: return 4;
      ALIGN_4K:  return 10;
      default:   return 0;
    endcase
  endfunction
endpackage

// File: rtl/tvec_legalize.sv
module tvec_legalize #(
  parameter int XLEN        = 32,
  parameter bit VEC_EN      = 1'b1,
  parameter bit MAP_ILLEGAL = 1'b0,
  parameter int ALIGN_LVL   = 0
) (
  input  logic [XLEN-1:0] wr_data,
  input  logic [1:0]      cur_mode,
  output logic [XLEN-1:0] nxt_d
);
  import tvec_pkg::*;
  localparam int CLR = clear_span(ALIGN_LVL);

  logic [1:0] mode_d;

  // base field with optional alignment clearing
  for (genvar g = 2; g < XLEN; g++) begin : g_base
    if (g < 2 + CLR) begin : g_clr
      assign nxt_d[g] = 1'b0;
    end else begin : g_keep
      assign nxt_d[g] = wr_data[g];
    end
  end

  // mode field legalization variants
  if (!VEC_EN) begin : g_direct_only
    logic [1:0] unused_bits;
    assign unused_bits = wr_data[1:0] ^ cur_mode;
    assign mode_d = MODE_DIRECT;
  end else if (MAP_ILLEGAL) begin : g_map
    logic [1:0] unused_bits;
    assign unused_bits = {wr_data[1], 1'b0} ^ cur_mode;
    assign mode_d = {1'b0, wr_data[0]};
  end else begin : g_keep_prev
    always_comb begin
      if (wr_data[1]) mode_d = cur_mode;
      else            mode_d = {1'b0, wr_data[0]};
    end
  end

  assign nxt_d[1:0] = mode_d;
endmodule

// File: rtl/tvec_target.sv
module tvec_target #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [XLEN-1:0]    csr_q,
  input  logic               trap_req,
  input  logic               trap_irq,
  input  logic [CAUSE_W-1:0] trap_cause,
  output logic [XLEN-1:0]    trap_pc,
  output logic               trap_pc_vld
);
  import tvec_pkg::*;
  localparam int PAD_W = XLEN - CAUSE_W - 2;

  logic [XLEN-1:0] base_w;
  logic [XLEN-1:0] offs_w;
  logic            use_vec;

  assign base_w  = {csr_q[XLEN-1:2], 2'b00};
  assign offs_w  = {{PAD_W{1'b0}}, trap_cause, 2'b00};
  assign use_vec = (csr_q[1:0] == MODE_VECTORED) && trap_irq;

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_pc     <= '0;
      trap_pc_vld <= 1'b0;
    end else begin
      trap_pc_vld <= trap_req;
      if (trap_req) trap_pc <= use_vec ? base_w + offs_w : base_w;
    end
  end

  // R12
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> trap_pc_vld);
  // R12
  vld_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !trap_req |=> !trap_pc_vld);
  // R11
  exc_base_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_req && !trap_irq) |=> (trap_pc[1:0] == 2'b00) &&
      (trap_pc[XLEN-1:2] == $past(csr_q[XLEN-1:2])));
  // R9
  direct_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_req && csr_q[1:0] == 2'b00) |=>
      (trap_pc[XLEN-1:2] == $past(csr_q[XLEN-1:2])));
endmodule

// File: rtl/tvec_reg.sv
module tvec_reg #(
  parameter int XLEN        = 32,
  parameter int CAUSE_W     = 6,
  parameter bit VEC_EN      = 1'b1,
  parameter bit MAP_ILLEGAL = 1'b0,
  parameter int ALIGN_LVL   = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [XLEN-1:0]    wr_data,
  output logic [XLEN-1:0]    rd_data,
  input  logic               trap_req,
  input  logic               trap_irq,
  input  logic [CAUSE_W-1:0] trap_cause,
  output logic [XLEN-1:0]    trap_pc,
  output logic               trap_pc_vld
);
  import tvec_pkg::*;
  localparam int CLR = clear_span(ALIGN_LVL);
  localparam logic [XLEN-1:0] LOW_MASK =
    ((XLEN'(1) << (2 + CLR)) - XLEN'(1)) & ~XLEN'(2);

  logic [XLEN-1:0] csr_q;
  logic [XLEN-1:0] nxt_d;

  tvec_legalize #(
    .XLEN(XLEN), .VEC_EN(VEC_EN), .MAP_ILLEGAL(MAP_ILLEGAL), .ALIGN_LVL(ALIGN_LVL)
  ) u_legal (
    .wr_data(wr_data), .cur_mode(csr_q[1:0]), .nxt_d(nxt_d)
  );

  always_ff @(posedge clk) begin
    if (rst)        csr_q <= '0;
    else if (wr_en) csr_q <= nxt_d;
  end

  assign rd_data = csr_q;

  tvec_target #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_target (
    .clk(clk), .rst(rst), .csr_q(csr_q),
    .trap_req(trap_req), .trap_irq(trap_irq), .trap_cause(trap_cause),
    .trap_pc(trap_pc), .trap_pc_vld(trap_pc_vld)
  );

  // R3
  bit1_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !rd_data[1]);
  // R6 R7 (bit 0 excluded from mask: it is mode)
  align_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((rd_data & LOW_MASK & ~XLEN'(3)) == '0));
  // R4
  keep_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[1] && VEC_EN && !MAP_ILLEGAL) |=>
      (rd_data[1:0] == $past(rd_data[1:0])));
  // R8
  direct_only_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !VEC_EN) |=> (rd_data[1:0] == 2'b00));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data));
endmodule

// File: tb/tvec_reg_test.sv
module tvec_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int XL = 32;
  localparam int CW = 6;
  localparam int NI = 3;
  localparam int CFG_VEC [NI] = '{1, 1, 0};
  localparam int CFG_MAP [NI] = '{0, 1, 0};
  localparam int CFG_ALN [NI] = '{0, 1, 2};

  typedef struct {
    logic [NI-1:0][XL-1:0] rd;
    logic [NI-1:0][XL-1:0] pc;
    logic                  trap;
    string                 tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [XL-1:0] wr_data = '0;
  logic trap_req = 1'b0;
  logic trap_irq = 1'b0;
  logic [CW-1:0] trap_cause = '0;
  logic [NI-1:0][XL-1:0] rd_o;
  logic [NI-1:0][XL-1:0] pc_o;
  logic [NI-1:0] vld_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  item_t sb[$];
  logic [NI-1:0][XL-1:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  tvec_reg #(.XLEN(XL), .CAUSE_W(CW), .VEC_EN(1'b1), .MAP_ILLEGAL(1'b0), .ALIGN_LVL(0)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_o[0]),
    .trap_req(trap_req), .trap_irq(trap_irq), .trap_cause(trap_cause),
    .trap_pc(pc_o[0]), .trap_pc_vld(vld_o[0]));
  tvec_reg #(.XLEN(XL), .CAUSE_W(CW), .VEC_EN(1'b1), .MAP_ILLEGAL(1'b1), .ALIGN_LVL(1)) uut_map (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_o[1]),
    .trap_req(trap_req), .trap_irq(trap_irq), .trap_cause(trap_cause),
    .trap_pc(pc_o[1]), .trap_pc_vld(vld_o[1]));
  tvec_reg #(.XLEN(XL), .CAUSE_W(CW), .VEC_EN(1'b0), .MAP_ILLEGAL(1'b0), .ALIGN_LVL(2)) uut_dir (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_o[2]),
    .trap_req(trap_req), .trap_irq(trap_irq), .trap_cause(trap_cause),
    .trap_pc(pc_o[2]), .trap_pc_vld(vld_o[2]));

  function automatic logic [XL-1:0] legal(int i, logic [XL-1:0] prev, logic [XL-1:0] w);
    logic [1:0] md;
    logic [XL-1:0] b;
    int clr;
    clr = (CFG_ALN[i] == 1) ? 4 : (CFG_ALN[i] == 2) ? 10 : 0;
    b = {w[XL-1:2], 2'b00};
    for (int k = 2; k < 2 + clr; k++) b[k] = 1'b0;
    if (CFG_VEC[i] == 0)      md = 2'b00;
    else if (!w[1])           md = w[1:0];
    else if (CFG_MAP[i] == 1) md = {1'b0, w[0]};
    else                      md = prev[1:0];
    return b | {{(XL-2){1'b0}}, md};
  endfunction

  function automatic logic [XL-1:0] target(logic [XL-1:0] r, logic irq, logic [CW-1:0] c);
    logic [XL-1:0] b;
    b = {r[XL-1:2], 2'b00};
    if (r[1:0] == 2'b01 && irq) return b + {{(XL-CW-2){1'b0}}, c, 2'b00};
    return b;
  endfunction

  task automatic chk(string tag, string what, int i, logic [XL-1:0] act, logic [XL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s inst%0d actual=%h expected=%h", tag, what, i, act, exp);
    end
  endtask

  // driver: drive at negedge, push expected result for the following edge
  task automatic op(logic we, logic [XL-1:0] wd, logic tr, logic irq, logic [CW-1:0] c, string tag);
    item_t it;
    @(negedge clk);
    wr_en = we; wr_data = wd; trap_req = tr; trap_irq = irq; trap_cause = c;
    for (int i = 0; i < NI; i++) begin
      it.pc[i] = target(model[i], irq, c);
      if (we) model[i] = legal(i, model[i], wd);
      it.rd[i] = model[i];
    end
    it.trap = tr;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: sample 2 time units after the active edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        for (int i = 0; i < NI; i++) begin
          chk(it.tag, "rd_data", i, rd_o[i], it.rd[i]);
          chk(it.tag, "trap_pc_vld(R12)", i, {31'b0, vld_o[i]}, {31'b0, it.trap});
          if (it.trap) chk(it.tag, "trap_pc", i, pc_o[i], it.pc[i]);
        end
      end
    end
  end

  initial begin
    logic [XL-1:0] lf;
    model = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    op(1'b0, '0, 1'b0, 1'b0, '0, "R1 reset state");
    op(1'b1, 32'h0000_1001, 1'b0, 1'b0, '0, "R2 R6 R7 R8 write vectored");
    op(1'b0, '0, 1'b1, 1'b1, 6'd5, "R10 R9 irq cause 5");
    op(1'b0, '0, 1'b1, 1'b0, 6'd7, "R11 exception");
    op(1'b1, 32'h0000_2346, 1'b0, 1'b0, '0, "R4 R5 R3 write mode 10");
    op(1'b0, '0, 1'b1, 1'b1, 6'd3, "R4 R10 irq after keep");
    op(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, '0, "R5 R3 R6 R7 write all ones");
    op(1'b0, '0, 1'b1, 1'b1, 6'd63, "R10 max cause");
    op(1'b1, 32'hABCD_EF7C, 1'b1, 1'b1, 6'd2, "R12 R2 write with trap same cycle");
    op(1'b0, '0, 1'b1, 1'b1, 6'd2, "R9 R10 after direct write");
    op(1'b1, 32'h1234_5677, 1'b0, 1'b0, '0, "R4 R5 write mode 11");
    op(1'b1, 32'h0F0F_0F0E, 1'b0, 1'b0, '0, "R4 R5 write mode 10 again");
    op(1'b0, '0, 1'b1, 1'b1, 6'd9, "R10 R9 irq cause 9");
    lf = 32'hACE1_2468;
    for (int n = 0; n < 40; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      op(lf[3], lf, lf[7], lf[9], lf[15:10], "R2 R3 R4 R5 R10 R11 R12 random");
    end
    op(1'b0, '0, 1'b0, 1'b0, '0, "R12 idle");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule